// File: doc/BRIEF.md
# FIFO Watermark Interrupt Controller

This block collects the interrupt causes of a serial controller that moves data through a transmit FIFO and a receive FIFO. It watches both FIFO occupancy counts and compares them against two programmable watermarks. From these comparisons it raises four level conditions: transmit below watermark, transmit full, receive not empty and receive at watermark. It also latches two event pulses, receive overflow and transmit underflow. The causes gather in a status word that software clears by writing ones. An interrupt mask is built up through a write-only set register and a write-only clear register, and a read-only register shows the mask. One registered interrupt line leaves the block.

The FIFO storage and the serial engine are outside this block. They provide the occupancy counts and the single-cycle event pulses. Software reaches the block through a simple register port. A write happens in the cycle that `reg_wr` is high. The read data is registered and reflects the address presented in the previous cycle.

Top module: `qwm_irq_ctrl`

## Requirements
- R1: After synchronous reset the status word and the mask are zero, `irq` is low, the transmit watermark is 1 and the receive watermark is 32.
- R2: Status bit positions: bit 0 receive overflow event, bit 2 set while `tx_level` is below the transmit watermark, bit 3 set while `tx_level` equals DEPTH (63), bit 4 set while `rx_level` is non-zero, bit 5 set while `rx_level` is at or above the receive watermark, bit 6 transmit underflow event. All other bits always read 0.
- R3: Register offsets: status 0x04 (read, write-one-to-clear), mask set 0x08 (write-only, reads 0), mask clear 0x0C (write-only, reads 0), mask view 0x10 (read-only), transmit watermark 0x28 and receive watermark 0x2C (read/write, low 6 bits).
- R4: Writing a 1 to a status bit clears it. Writing a 0 leaves the bit unchanged. A set bit stays set until software clears it.
- R5: If a level condition still holds when its bit is cleared, the bit reads 0 for one cycle and is set again on the following cycle.
- R6: An event bit, once cleared, stays 0 until a new pulse arrives. A pulse in the same cycle as a clear of that bit leaves the bit set.
- R7: A write to the set register ORs the written bits into the mask. A write to the clear register removes the written bits from the mask. Only the six defined bit positions can be held, so the mask reads at most 0x7D.
- R8: `irq` is the OR over status AND mask, registered once. It follows a status or mask change one cycle later.
- R9: The watermarks are writable and their new values immediately change the thresholds of bits 2 and 5.
- R10: `reg_rdata` shows, one cycle later, the register selected by `reg_addr`. A status bit cleared by a write reads 0 on the read issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| tx_level | input | 6 | Transmit FIFO occupancy in words |
| rx_level | input | 6 | Receive FIFO occupancy in words |
| rx_ovf_evt | input | 1 | One-cycle pulse: receive FIFO overflowed |
| tx_udf_evt | input | 1 | One-cycle pulse: transmit FIFO underflowed |
| irq | output | 1 | Registered interrupt request |

## Verification
A bad status bit shows up on the next read of offset 0x04. If that bit is unmasked, `irq` goes wrong one cycle after the bit itself. A mask bit that is lost or sticks shows at once on the 0x10 view, and on `irq` one cycle after the mask changes. The timing that is easiest to get wrong is the one-cycle gap when a level bit is cleared. The stimulus therefore reads the status word on the cycle right after each clear and again one cycle later, and it also clears an event bit in the same cycle as a new pulse.

// File: rtl/qwm_pkg.sv
package qwm_pkg;
  localparam int NFLAG = 7;
  typedef logic [NFLAG-1:0] flag_t;

  localparam int B_RXOVF  = 0;
  localparam int B_TXLOW  = 2;
  localparam int B_TXFULL = 3;
  localparam int B_RXNE   = 4;
  localparam int B_RXHI   = 5;
  localparam int B_TXUDF  = 6;

  localparam flag_t IMPL_MASK = flag_t'(7'b111_1101);

  localparam logic [7:0] A_STAT = 8'h04;
  localparam logic [7:0] A_MSET = 8'h08;
  localparam logic [7:0] A_MCLR = 8'h0C;
  localparam logic [7:0] A_MVIEW = 8'h10;
  localparam logic [7:0] A_TXWM = 8'h28;
  localparam logic [7:0] A_RXWM = 8'h2C;
endpackage

// File: rtl/qwm_cond.sv
module qwm_cond
  import qwm_pkg::*;
#(
  parameter int DEPTH = 63,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_wm,
  input  logic [LVL_W-1:0] rx_wm,
  input  logic             rx_ovf_evt,
  input  logic             tx_udf_evt,
  output flag_t            lvl,
  output flag_t            evt
);
  localparam logic [LVL_W-1:0] FULL_CNT = LVL_W'(DEPTH);

  always_comb begin
    lvl = '0;
    evt = '0;
    lvl[B_TXLOW]  = tx_level < tx_wm;
    lvl[B_TXFULL] = tx_level == FULL_CNT;
    lvl[B_RXNE]   = rx_level != '0;
    lvl[B_RXHI]   = rx_level >= rx_wm;
    evt[B_RXOVF]  = rx_ovf_evt;
    evt[B_TXUDF]  = tx_udf_evt;
  end
endmodule

// File: rtl/qwm_status.sv
module qwm_status
  import qwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  flag_t lvl,
  input  flag_t evt,
  input  flag_t clr,
  output flag_t st_q
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      always_ff @(posedge clk) begin
        if (rst) st_q[i] <= 1'b0;
        else     st_q[i] <= ((st_q[i] | lvl[i]) & ~clr[i]) | evt[i];
      end

      // R5: an uncleared level condition is latched
      a_r5_level_sets: assert property (@(posedge clk) disable iff (rst)
        (lvl[i] && !clr[i]) |=> st_q[i]);
      // R4: a set bit holds until it is cleared
      a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q[i] && !clr[i]) |=> st_q[i]);
      // R4: a clear with no fresh cause empties the bit
      a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        (clr[i] && !lvl[i] && !evt[i]) |=> !st_q[i]);
      // R6: an event pulse beats a clear in the same cycle
      a_r6_evt_wins: assert property (@(posedge clk) disable iff (rst)
        evt[i] |=> st_q[i]);
    end else begin : g_rsv
      assign st_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/qwm_mask.sv
module qwm_mask
  import qwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  set_wr,
  input  logic  clr_wr,
  input  flag_t wbits,
  output flag_t mask_q
);
  flag_t set_v, clr_v;

  always_comb begin
    set_v = set_wr ? (wbits & IMPL_MASK) : '0;
    clr_v = clr_wr ? wbits : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= (mask_q | set_v) & ~clr_v;
  end

  a_r7_set_ors: assert property (@(posedge clk) disable iff (rst)
    (set_wr && !clr_wr) |=> ((mask_q & $past(wbits & IMPL_MASK)) == $past(wbits & IMPL_MASK)));
  a_r7_clr_removes: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((mask_q & $past(wbits)) == '0));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!set_wr && !clr_wr) |=> $stable(mask_q));
endmodule

// File: rtl/qwm_irq.sv
module qwm_irq
  import qwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  flag_t st,
  input  flag_t mask,
  output logic  irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(st & mask);
  end

  a_r8_raise: assert property (@(posedge clk) disable iff (rst)
    (|(st & mask)) |=> irq_q);
  a_r8_drop: assert property (@(posedge clk) disable iff (rst)
    (!(|(st & mask))) |=> !irq_q);
endmodule

// File: rtl/qwm_irq_ctrl.sv
module qwm_irq_ctrl
  import qwm_pkg::*;
#(
  parameter int DEPTH    = 63,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int TXWM_RST = 1,
  parameter int RXWM_RST = 32,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_ovf_evt,
  input  logic              tx_udf_evt,
  output logic              irq
);
  logic [LVL_W-1:0] tx_wm_q, rx_wm_q;
  flag_t lvl, evt, st_q, mask_q, clr_bits, wbits;
  logic  wr_stat, wr_mset, wr_mclr, wr_txwm, wr_rxwm;

  assign wbits    = reg_wdata[NFLAG-1:0];
  assign wr_stat  = reg_wr && (reg_addr == ADDR_W'(A_STAT));
  assign wr_mset  = reg_wr && (reg_addr == ADDR_W'(A_MSET));
  assign wr_mclr  = reg_wr && (reg_addr == ADDR_W'(A_MCLR));
  assign wr_txwm  = reg_wr && (reg_addr == ADDR_W'(A_TXWM));
  assign wr_rxwm  = reg_wr && (reg_addr == ADDR_W'(A_RXWM));
  assign clr_bits = wr_stat ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_wm_q <= LVL_W'(TXWM_RST);
      rx_wm_q <= LVL_W'(RXWM_RST);
    end else begin
      if (wr_txwm) tx_wm_q <= reg_wdata[LVL_W-1:0];
      if (wr_rxwm) rx_wm_q <= reg_wdata[LVL_W-1:0];
    end
  end

  qwm_cond #(.DEPTH(DEPTH)) u_cond (
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_wm(tx_wm_q), .rx_wm(rx_wm_q),
    .rx_ovf_evt(rx_ovf_evt), .tx_udf_evt(tx_udf_evt),
    .lvl(lvl), .evt(evt)
  );

  qwm_status u_status (
    .clk(clk), .rst(rst), .lvl(lvl), .evt(evt), .clr(clr_bits), .st_q(st_q)
  );

  qwm_mask u_mask (
    .clk(clk), .rst(rst), .set_wr(wr_mset), .clr_wr(wr_mclr),
    .wbits(wbits), .mask_q(mask_q)
  );

  qwm_irq u_irq (
    .clk(clk), .rst(rst), .st(st_q), .mask(mask_q), .irq_q(irq)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(A_STAT):  rd_mux = DATA_W'(st_q);
      ADDR_W'(A_MVIEW): rd_mux = DATA_W'(mask_q);
      ADDR_W'(A_TXWM):  rd_mux = DATA_W'(tx_wm_q);
      ADDR_W'(A_RXWM):  rd_mux = DATA_W'(rx_wm_q);
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  // R9: a watermark write lands in the threshold register
  a_r9_txwm_write: assert property (@(posedge clk) disable iff (rst)
    wr_txwm |=> (tx_wm_q == $past(reg_wdata[LVL_W-1:0])));
  a_r9_rxwm_write: assert property (@(posedge clk) disable iff (rst)
    wr_rxwm |=> (rx_wm_q == $past(reg_wdata[LVL_W-1:0])));
  // R10: a mask view read returns the mask one cycle later
  a_r10_view_read: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_W'(A_MVIEW)) |=> (reg_rdata == DATA_W'($past(mask_q))));
endmodule

// File: tb/qwm_irq_ctrl_tb.sv
module qwm_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  tx_level = 6'd5;
  logic [5:0]  rx_level = 6'd0;
  logic        rx_ovf_evt = 1'b0;
  logic        tx_udf_evt = 1'b0;
  logic        irq;

  always #2.5 clk = ~clk;

  qwm_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_level(tx_level), .rx_level(rx_level),
    .rx_ovf_evt(rx_ovf_evt), .tx_udf_evt(tx_udf_evt), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req = 1'b0;
  logic        rd_pend = 1'b0;

  always @(posedge clk) rd_pend <= rd_req;

  // monitor: pops the expected read data when the response is due
  always @(negedge clk) begin
    if (rd_pend) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (reg_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata=%08h expected=%08h", t, reg_rdata, e);
      end
    end
  end

  // all tasks start and end on a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_addr = a; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; reg_addr = 8'h00;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq=%0b expected=%0b", t, irq, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_irq(1'b0, "R1 irq in reset");
    rst = 1'b0;
    @(negedge clk);
    chk_irq(1'b0, "R1 irq after reset");
    rd(8'h04, 32'h0, "R1 status reset");
    rd(8'h10, 32'h0, "R1 mask reset");
    rd(8'h28, 32'd1, "R1 tx watermark reset");
    rd(8'h2C, 32'd32, "R1 rx watermark reset");
    rd(8'h08, 32'h0, "R3 set register reads zero");

    // receive not empty level
    rx_level = 6'd3;
    @(negedge clk);
    rd(8'h04, 32'h10, "R2 rx not empty bit4");
    chk_irq(1'b0, "R8 masked cause gives no irq");

    wr(8'h08, 32'h10);
    chk_irq(1'b0, "R8 irq one cycle after mask");
    @(negedge clk);
    chk_irq(1'b1, "R8 irq raised");
    rd(8'h10, 32'h10, "R7 mask view after set");
    rd(8'h0C, 32'h0, "R3 clear register reads zero");

    // clear with condition still true
    wr(8'h04, 32'h10);
    rd(8'h04, 32'h0, "R5 R10 bit reads 0 right after clear");
    rd(8'h04, 32'h10, "R5 level bit re-asserts");

    // writing zero has no effect
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h10, "R4 writing 0 keeps bit");

    // condition gone, clear sticks
    rx_level = 6'd0;
    @(negedge clk);
    rd(8'h04, 32'h10, "R4 level bit sticky after condition ends");
    wr(8'h04, 32'h10);
    rd(8'h04, 32'h0, "R4 cleared");
    rd(8'h04, 32'h0, "R4 stays cleared");
    rx_level = 6'd3;
    @(negedge clk);

    // receive overflow event
    rx_ovf_evt = 1'b1;
    @(negedge clk);
    rx_ovf_evt = 1'b0;
    rd(8'h04, 32'h11, "R2 overflow bit0");
    rd(8'h04, 32'h11, "R6 overflow sticky");
    wr(8'h04, 32'h01);
    rd(8'h04, 32'h10, "R6 overflow cleared");
    rd(8'h04, 32'h10, "R6 overflow stays cleared");

    // underflow pulse coincident with its clear
    tx_udf_evt = 1'b1;
    wr(8'h04, 32'h40);
    tx_udf_evt = 1'b0;
    rd(8'h04, 32'h50, "R6 pulse beats clear");
    wr(8'h04, 32'h40);
    rd(8'h04, 32'h10, "R6 underflow cleared");

    // mask set / clear
    wr(8'h08, 32'h41);
    rd(8'h10, 32'h51, "R7 set ORs bits");
    wr(8'h0C, 32'h11);
    rd(8'h10, 32'h40, "R7 clear removes bits");
    chk_irq(1'b0, "R8 irq drops when cause masked");

    // underflow through irq
    tx_udf_evt = 1'b1;
    @(negedge clk);
    tx_udf_evt = 1'b0;
    chk_irq(1'b0, "R8 irq latency from event");
    @(negedge clk);
    chk_irq(1'b1, "R2 R8 underflow bit6 raises irq");
    wr(8'h04, 32'h40);
    chk_irq(1'b1, "R8 irq held one cycle after clear");
    @(negedge clk);
    chk_irq(1'b0, "R8 irq drops after clear");

    // transmit watermark
    wr(8'h28, 32'd8);
    rd(8'h28, 32'd8, "R9 tx watermark readback");
    rd(8'h04, 32'h14, "R9 tx below new watermark bit2");
    tx_level = 6'd8;
    wr(8'h04, 32'h04);
    rd(8'h04, 32'h10, "R2 tx at watermark not below");
    rd(8'h04, 32'h10, "R2 bit2 stays cleared");
    tx_level = 6'd63;
    @(negedge clk);
    rd(8'h04, 32'h18, "R2 tx full bit3");

    // receive watermark
    wr(8'h2C, 32'd4);
    rx_level = 6'd4;
    @(negedge clk);
    rd(8'h04, 32'h38, "R9 rx at watermark bit5");
    rx_level = 6'd3;
    wr(8'h04, 32'h20);
    rd(8'h04, 32'h18, "R2 rx below watermark clears");
    rd(8'h04, 32'h18, "R2 bit5 stays cleared");

    // undefined positions
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h10, 32'h7D, "R7 mask keeps defined bits");
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0, "R2 all bits cleared");
    rd(8'h04, 32'h18, "R2 R5 only level bits return");
    idle(2);
    chk_irq(1'b1, "R8 irq with full mask");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule